// File: doc/BRIEF.md
# Prioritized Exception Entry Controller

This block arbitrates pending exception requests for a processor core that banks its status and link registers per mode. Every cycle it looks at six request lines: data abort, fast interrupt, normal interrupt, prefetch abort, software interrupt and undefined instruction. Reset is the seventh source and arrives on the asynchronous reset pin. The two interrupt lines are gated by mask bits in the current status word. A fixed priority chain picks one winner. On entry the block saves the current status and the supplied link value into the bank of the target mode, sets the new mode and mask bits, and issues a one-cycle fetch redirect to the vector of that exception.

An exception return reads the bank of the current mode. It restores the saved status word and redirects fetch to the stored link value, less an offset that depends on which exception filled the bank. Software may also write the status word directly. A privileged mode may write the whole word. User mode may change only the condition flags.

The controller is a four-state machine. BOOT is the single cycle after reset is released. RUN is idle. VECTOR presents an entry redirect and RESUME presents a return redirect. Every transition out of RUN, VECTOR or RESUME follows the same rule: an accepted exception leads to VECTOR, an accepted return leads to RESUME, and anything else leads to RUN. BOOT always moves to RUN.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it rises (state BOOT), the status word is 0x000000D3 (supervisor mode, both masks set). In that cycle `redirect` is 1 and `redirect_addr` is 0. Requests, returns and writes made in the BOOT cycle are ignored.
- R2: The winner among the active requests is chosen by fixed priority, highest first: data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R3: Status bit 7 set blocks the normal-interrupt request. Status bit 6 set blocks the fast-interrupt request. A blocked request causes no redirect and no status change.
- R4: The status mode field is bits [4:0]. Entry writes the target mode: fast interrupt 10001 (vector 0x1C), normal interrupt 10010 (0x18), software interrupt 10011 (0x08), data abort 10111 (0x10), prefetch abort 10111 (0x0C), undefined 11011 (0x04).
- R5: Every entry sets bit 7. Only fast-interrupt entry sets bit 6. Every other entry keeps bit 6 as it was.
- R6: Entry stores the pre-entry status word in the bank of the target mode. A return from that mode restores this word exactly, even when one exception was taken inside another.
- R7: A return redirects to the stored link value minus 8 after data abort, minus 4 after fast interrupt, normal interrupt or prefetch abort, and minus 0 after software interrupt or undefined instruction.
- R8: A return request is ignored in user mode (10000), in system mode (11111), and in supervisor mode while that mode's bank still holds the reset entry. No redirect is issued and the status word is unchanged.
- R9: In a privileged mode a direct write replaces the whole status word. If the written mode field is not one of the seven legal encodings, the mode field keeps its old value and the other bits are still written.
- R10: In user mode a direct write changes only bits [31:28].
- R11: When several actions fall in the same cycle, an exception entry beats a return, and a return beats a direct write. Each losing action is dropped.
- R12: When the software-interrupt and undefined-instruction requests are both active, and nothing higher is active, undefined instruction is taken.
- R13: `redirect` is high for exactly one cycle: the cycle after an accepted entry or return (apart from the BOOT cycle). Its address is valid only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also the reset exception |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_swi | input | 1 | Software interrupt request |
| req_und | input | 1 | Undefined instruction request |
| link_addr | input | XLEN | Link value recorded on entry |
| ret_req | input | 1 | Exception return request |
| sr_wr_en | input | 1 | Direct status write strobe |
| sr_wr_data | input | XLEN | Direct status write value |
| status | output | XLEN | Current status word |
| redirect | output | 1 | Fetch redirect strobe |
| redirect_addr | output | XLEN | Fetch redirect target |

## Verification
An exception entry and an exception return can be requested in the same cycle. So can an entry and a direct status write, or a return and a direct write. The bench provokes each pair by asserting both inputs in a single cycle: a prefetch abort together with a return while in normal-interrupt mode, a software interrupt together with a write, and a return together with a write. It judges the outcome by two things. The redirect address must be that of the winning action. The status word must show no trace of the dropped action, checked in the cycle after acceptance and again when the surviving bank is later unwound.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int MODE_W    = 5;
    localparam int IMASK_BIT = 7;
    localparam int FMASK_BIT = 6;
    localparam int FLAG_LSB  = 28;
    localparam int NBANK     = 5;
    localparam int BANK_W    = $clog2(NBANK + 1);
    localparam int VEC_W     = 8;
    localparam int OFF_W     = 4;

    typedef enum logic [MODE_W-1:0] {
        M_USR = 5'b10000,
        M_FIQ = 5'b10001,
        M_IRQ = 5'b10010,
        M_SVC = 5'b10011,
        M_ABT = 5'b10111,
        M_UND = 5'b11011,
        M_SYS = 5'b11111
    } mode_e;

    typedef enum logic [2:0] {
        K_NONE, K_RESET, K_DABT, K_FIQ, K_IRQ, K_PABT, K_SWI, K_UND
    } kind_e;

    typedef enum logic [1:0] {
        S_BOOT, S_RUN, S_VECTOR, S_RESUME
    } state_e;

    localparam logic [BANK_W-1:0] BANK_NONE = '1;
    localparam logic [BANK_W-1:0] BANK_SVC  = BANK_W'(2);

    function automatic mode_e kind_mode(kind_e k);
        mode_e m;
        unique case (k)
            K_FIQ:          m = M_FIQ;
            K_IRQ:          m = M_IRQ;
            K_DABT, K_PABT: m = M_ABT;
            K_UND:          m = M_UND;
            default:        m = M_SVC;
        endcase
        return m;
    endfunction

    function automatic logic [VEC_W-1:0] kind_vector(kind_e k);
        logic [VEC_W-1:0] v;
        unique case (k)
            K_UND:   v = 8'h04;
            K_SWI:   v = 8'h08;
            K_PABT:  v = 8'h0C;
            K_DABT:  v = 8'h10;
            K_IRQ:   v = 8'h18;
            K_FIQ:   v = 8'h1C;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic [OFF_W-1:0] kind_ret_off(kind_e k);
        logic [OFF_W-1:0] o;
        unique case (k)
            K_DABT:               o = 4'd8;
            K_FIQ, K_IRQ, K_PABT: o = 4'd4;
            default:              o = 4'd0;
        endcase
        return o;
    endfunction

    function automatic logic [BANK_W-1:0] mode_bank(logic [MODE_W-1:0] m);
        logic [BANK_W-1:0] b;
        unique case (m)
            M_FIQ:   b = BANK_W'(0);
            M_IRQ:   b = BANK_W'(1);
            M_SVC:   b = BANK_SVC;
            M_ABT:   b = BANK_W'(3);
            M_UND:   b = BANK_W'(4);
            default: b = BANK_NONE;
        endcase
        return b;
    endfunction

    function automatic logic mode_legal(logic [MODE_W-1:0] m);
        logic ok;
        unique case (m)
            M_USR, M_FIQ, M_IRQ, M_SVC, M_ABT, M_UND, M_SYS: ok = 1'b1;
            default:                                         ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_pkg::*;
(
    input  logic  req_dabt,
    input  logic  req_fiq,
    input  logic  req_irq,
    input  logic  req_pabt,
    input  logic  req_swi,
    input  logic  req_und,
    input  logic  mask_i,
    input  logic  mask_f,
    output kind_e win
);

    always_comb begin
        if (req_dabt)                 win = K_DABT;
        else if (req_fiq && !mask_f)  win = K_FIQ;
        else if (req_irq && !mask_i)  win = K_IRQ;
        else if (req_pabt)            win = K_PABT;
        else if (req_und)             win = K_UND;
        else if (req_swi)             win = K_SWI;
        else                          win = K_NONE;
    end

endmodule

// File: rtl/exc_bank.sv
module exc_bank
    import exc_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NB   = NBANK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BANK_W-1:0] wr_idx,
    input  logic [XLEN-1:0]   wr_sr,
    input  logic [XLEN-1:0]   wr_lr,
    input  kind_e             wr_kind,
    input  logic [BANK_W-1:0] rd_idx,
    output logic [XLEN-1:0]   rd_sr,
    output logic [XLEN-1:0]   rd_lr,
    output kind_e             rd_kind,
    output logic              rd_hit
);

    logic [XLEN-1:0] sr_all   [NB];
    logic [XLEN-1:0] lr_all   [NB];
    kind_e           kind_all [NB];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic [XLEN-1:0] sr_q;
        logic [XLEN-1:0] lr_q;
        kind_e           kind_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sr_q   <= '0;
                lr_q   <= '0;
                kind_q <= (BANK_W'(b) == BANK_SVC) ? K_RESET : K_NONE;
            end else if (wr_en && wr_idx == BANK_W'(b)) begin
                sr_q   <= wr_sr;
                lr_q   <= wr_lr;
                kind_q <= wr_kind;
            end
        end

        assign sr_all[b]   = sr_q;
        assign lr_all[b]   = lr_q;
        assign kind_all[b] = kind_q;
    end

    always_comb begin
        rd_sr   = '0;
        rd_lr   = '0;
        rd_kind = K_NONE;
        rd_hit  = 1'b0;
        for (int b = 0; b < NB; b++) begin
            if (rd_idx == BANK_W'(b)) begin
                rd_sr   = sr_all[b];
                rd_lr   = lr_all[b];
                rd_kind = kind_all[b];
                rd_hit  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/exc_status.sv
module exc_status
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  kind_e           kind,
    input  logic            ret_take,
    input  logic [XLEN-1:0] ret_sr,
    input  logic            wr_take,
    input  logic [XLEN-1:0] wr_data,
    output logic [XLEN-1:0] sr_q
);

    logic [XLEN-1:0] sr_d;

    always_comb begin
        sr_d = sr_q;
        if (take) begin
            sr_d[MODE_W-1:0] = kind_mode(kind);
            sr_d[IMASK_BIT]  = 1'b1;
            if (kind == K_FIQ) begin
                sr_d[FMASK_BIT] = 1'b1;
            end
        end else if (ret_take) begin
            sr_d = ret_sr;
        end else if (wr_take) begin
            if (sr_q[MODE_W-1:0] == M_USR) begin
                sr_d[XLEN-1:FLAG_LSB] = wr_data[XLEN-1:FLAG_LSB];
            end else begin
                sr_d = wr_data;
                if (!mode_legal(wr_data[MODE_W-1:0])) begin
                    sr_d[MODE_W-1:0] = sr_q[MODE_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q               <= '0;
            sr_q[MODE_W-1:0]   <= M_SVC;
            sr_q[IMASK_BIT]    <= 1'b1;
            sr_q[FMASK_BIT]    <= 1'b1;
        end else begin
            sr_q <= sr_d;
        end
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_dabt,
    input  logic            req_fiq,
    input  logic            req_irq,
    input  logic            req_pabt,
    input  logic            req_swi,
    input  logic            req_und,
    input  logic [XLEN-1:0] link_addr,
    input  logic            ret_req,
    input  logic            sr_wr_en,
    input  logic [XLEN-1:0] sr_wr_data,
    output logic [XLEN-1:0] status,
    output logic            redirect,
    output logic [XLEN-1:0] redirect_addr
);

    state_e            state_q, state_d;
    kind_e             win;
    logic              live, take, ret_take, wr_take;
    logic [BANK_W-1:0] rd_idx, wr_idx;
    logic [XLEN-1:0]   rd_sr, rd_lr, resume, tgt_q;
    kind_e             rd_kind;
    logic              rd_hit;

    assign live = (state_q != S_BOOT);

    exc_arbiter u_arb (
        .req_dabt (req_dabt),
        .req_fiq  (req_fiq),
        .req_irq  (req_irq),
        .req_pabt (req_pabt),
        .req_swi  (req_swi),
        .req_und  (req_und),
        .mask_i   (status[IMASK_BIT]),
        .mask_f   (status[FMASK_BIT]),
        .win      (win)
    );

    assign take   = live && (win != K_NONE);
    assign rd_idx = mode_bank(status[MODE_W-1:0]);
    assign wr_idx = mode_bank(kind_mode(win));

    exc_bank #(.XLEN(XLEN), .NB(NBANK)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (take),
        .wr_idx  (wr_idx),
        .wr_sr   (status),
        .wr_lr   (link_addr),
        .wr_kind (win),
        .rd_idx  (rd_idx),
        .rd_sr   (rd_sr),
        .rd_lr   (rd_lr),
        .rd_kind (rd_kind),
        .rd_hit  (rd_hit)
    );

    assign ret_take = live && !take && ret_req && rd_hit
                      && (rd_kind != K_RESET) && (rd_kind != K_NONE);
    assign wr_take  = live && !take && !ret_take && sr_wr_en;
    assign resume   = rd_lr - XLEN'(kind_ret_off(rd_kind));

    exc_status #(.XLEN(XLEN)) u_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .kind     (win),
        .ret_take (ret_take),
        .ret_sr   (rd_sr),
        .wr_take  (wr_take),
        .wr_data  (sr_wr_data),
        .sr_q     (status)
    );

    always_comb begin
        unique case (state_q)
            S_BOOT:                    state_d = S_RUN;
            S_RUN, S_VECTOR, S_RESUME: state_d = take     ? S_VECTOR :
                                                 ret_take ? S_RESUME : S_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_BOOT;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                tgt_q <= XLEN'(kind_vector(win));
            end else if (ret_take) begin
                tgt_q <= resume;
            end
        end
    end

    always_comb begin
        unique case (state_q)
            S_BOOT: begin
                redirect      = 1'b1;
                redirect_addr = '0;
            end
            S_VECTOR, S_RESUME: begin
                redirect      = 1'b1;
                redirect_addr = tgt_q;
            end
            S_RUN: begin
                redirect      = 1'b0;
                redirect_addr = '0;
            end
        endcase
    end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input state_e          state,
    input logic [XLEN-1:0] status,
    input logic [XLEN-1:0] redirect_addr
);

    localparam logic [XLEN-1:0] VEC_FIQ  = XLEN'(8'h1C);
    localparam logic [XLEN-1:0] VEC_IRQ  = XLEN'(8'h18);
    localparam logic [XLEN-1:0] BOOT_SR  = XLEN'(8'hD3);

    AST_BOOT_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_BOOT |-> status == BOOT_SR); // R1

    AST_IRQ_WAS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_VECTOR && redirect_addr == VEC_IRQ) |-> !$past(status[IMASK_BIT])); // R3

    AST_FIQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_VECTOR && redirect_addr == VEC_FIQ) |-> (status[MODE_W-1:0] == M_FIQ)); // R4

    AST_ENTRY_IMASK: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_VECTOR |-> status[IMASK_BIT]); // R5

    AST_FMASK_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_VECTOR && redirect_addr != VEC_FIQ) |-> status[FMASK_BIT] == $past(status[FMASK_BIT])); // R5

    AST_USER_FLAGS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[MODE_W-1:0] == M_USR) |=> (status[MODE_W-1:0] != M_USR || status[FLAG_LSB-1:0] == $past(status[FLAG_LSB-1:0]))); // R10

endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .state         (state_q),
    .status        (status),
    .redirect_addr (redirect_addr)
);

// File: tb/tb_exc_entry_ctrl.sv
`timescale 1ns/1ps
module tb_exc_entry_ctrl;

    localparam int XLEN = 32;
    localparam logic [5:0] RQ_DABT = 6'b100000;
    localparam logic [5:0] RQ_FIQ  = 6'b010000;
    localparam logic [5:0] RQ_IRQ  = 6'b001000;
    localparam logic [5:0] RQ_PABT = 6'b000100;
    localparam logic [5:0] RQ_SWI  = 6'b000010;
    localparam logic [5:0] RQ_UND  = 6'b000001;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst_n;
    logic [5:0]      rq;
    logic [XLEN-1:0] link_addr, sr_wr_data, status, redirect_addr;
    logic            ret_req, sr_wr_en, redirect;

    exc_entry_ctrl #(.XLEN(XLEN)) dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_dabt      (rq[5]),
        .req_fiq       (rq[4]),
        .req_irq       (rq[3]),
        .req_pabt      (rq[2]),
        .req_swi       (rq[1]),
        .req_und       (rq[0]),
        .link_addr     (link_addr),
        .ret_req       (ret_req),
        .sr_wr_en      (sr_wr_en),
        .sr_wr_data    (sr_wr_data),
        .status        (status),
        .redirect      (redirect),
        .redirect_addr (redirect_addr)
    );

    int checks = 0;
    int errors = 0;
    logic mon_on = 1'b0;
    logic done = 1'b0;

    typedef struct {
        logic [31:0] addr;
        logic [31:0] sr;
        string       tag;
    } item_t;
    item_t exp_q[$];

    logic [31:0] m_sr;
    logic [31:0] m_spsr [5];
    logic [31:0] m_lr   [5];
    int          m_kind [5];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // kinds: 2 dabt 3 fiq 4 irq 5 pabt 6 swi 7 und (1 = reset)
    function automatic logic [4:0] mode_of(int k);
        case (k)
            2, 5:    return 5'b10111;
            3:       return 5'b10001;
            4:       return 5'b10010;
            7:       return 5'b11011;
            default: return 5'b10011;
        endcase
    endfunction

    function automatic logic [31:0] vec_of(int k);
        case (k)
            2:       return 32'h10;
            3:       return 32'h1C;
            4:       return 32'h18;
            5:       return 32'h0C;
            6:       return 32'h08;
            default: return 32'h04;
        endcase
    endfunction

    function automatic logic [31:0] off_of(int k);
        case (k)
            2:       return 32'd8;
            3, 4, 5: return 32'd4;
            default: return 32'd0;
        endcase
    endfunction

    function automatic int bank_of(logic [4:0] m);
        case (m)
            5'b10001: return 0;
            5'b10010: return 1;
            5'b10011: return 2;
            5'b10111: return 3;
            5'b11011: return 4;
            default:  return -1;
        endcase
    endfunction

    function automatic logic legal(logic [4:0] m);
        return (m == 5'b10000 || m == 5'b11111 || bank_of(m) >= 0);
    endfunction

    task automatic step(input logic [5:0] r, input logic ret, input logic wr,
                        input logic [31:0] wd, input logic [31:0] link, input string tag);
        int    k;
        int    b;
        item_t it;
        logic  pushed;
        @(negedge clk);
        rq = r; ret_req = ret; sr_wr_en = wr; sr_wr_data = wd; link_addr = link;
        pushed = 1'b0;
        k = 0;
        if (r[5])                   k = 2;
        else if (r[4] && !m_sr[6])  k = 3;
        else if (r[3] && !m_sr[7])  k = 4;
        else if (r[2])              k = 5;
        else if (r[0])              k = 7;
        else if (r[1])              k = 6;
        b = bank_of(m_sr[4:0]);
        if (k != 0) begin
            b = bank_of(mode_of(k));
            m_spsr[b] = m_sr; m_lr[b] = link; m_kind[b] = k;
            m_sr[4:0] = mode_of(k);
            m_sr[7] = 1'b1;
            if (k == 3) m_sr[6] = 1'b1;
            it.addr = vec_of(k); it.sr = m_sr; it.tag = tag;
            exp_q.push_back(it); pushed = 1'b1;
        end else if (ret && b >= 0 && m_kind[b] >= 2) begin
            it.addr = m_lr[b] - off_of(m_kind[b]);
            m_sr = m_spsr[b];
            it.sr = m_sr; it.tag = tag;
            exp_q.push_back(it); pushed = 1'b1;
        end else if (wr) begin
            if (m_sr[4:0] == 5'b10000) m_sr[31:28] = wd[31:28];
            else begin
                m_sr = legal(wd[4:0]) ? wd : {wd[31:5], m_sr[4:0]};
            end
        end
        @(posedge clk);
        #1;
        chk({tag, " status"}, status, m_sr);
        chk({tag, " R13 redirect strobe"}, {31'd0, redirect}, {31'd0, pushed});
        rq = '0; ret_req = 1'b0; sr_wr_en = 1'b0; sr_wr_data = '0; link_addr = '0;
    endtask

    // monitor: pops expected redirects as the design produces them
    always @(posedge clk) begin
        item_t it;
        #1;
        if (rst_n && mon_on && redirect) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R13 unexpected redirect actual %h expected none", redirect_addr);
            end else begin
                it = exp_q.pop_front();
                chk({it.tag, " redirect_addr"}, redirect_addr, it.addr);
                chk({it.tag, " status at redirect"}, status, it.sr);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rq = '0; ret_req = 1'b0; sr_wr_en = 1'b0;
        sr_wr_data = '0; link_addr = '0;
        m_sr = 32'h000000D3;
        for (int i = 0; i < 5; i++) begin
            m_spsr[i] = '0; m_lr[i] = '0; m_kind[i] = 0;
        end
        m_kind[2] = 1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 status in reset", status, 32'h000000D3);
        chk("R1 redirect in reset", {31'd0, redirect}, 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        rq = RQ_SWI;
        mon_on = 1'b1;
        #1;
        chk("R1 boot redirect", {31'd0, redirect}, 32'd1);
        chk("R1 boot address", redirect_addr, 32'h0);
        @(posedge clk);
        #1;
        chk("R1 request in boot ignored", status, 32'h000000D3);
        chk("R1 no redirect after boot", {31'd0, redirect}, 32'd0);
        rq = '0;

        step(6'd0,    1, 0, 0, 0,          "R8 return after reset");
        step(RQ_SWI,  0, 0, 0, 32'h100,    "R4 swi from svc");
        step(6'd0,    1, 0, 0, 0,          "R7 swi return");
        step(6'd0,    0, 1, 32'h1F, 0,     "R9 write system mode");
        step(6'd0,    1, 0, 0, 0,          "R8 return in system");
        step(6'd0,    0, 1, 32'h10, 0,     "R9 write user mode");
        step(6'd0,    0, 1, 32'hF00000DF, 0, "R10 user write flags only");
        step(6'd0,    1, 0, 0, 0,          "R8 return in user");
        step(6'h3F,   0, 0, 0, 32'h2000,   "R2 dabt wins");
        step(6'd0,    1, 0, 0, 0,          "R7 dabt return minus 8");
        step(RQ_FIQ | RQ_IRQ | RQ_PABT | RQ_SWI | RQ_UND, 0, 0, 0, 32'h3000, "R2 fiq over irq");
        step(6'd0,    1, 0, 0, 0,          "R7 fiq return minus 4");
        step(RQ_IRQ | RQ_PABT | RQ_SWI | RQ_UND, 0, 0, 0, 32'h4000, "R2 irq over pabt");
        step(RQ_PABT, 1, 0, 0, 32'h5000,   "R11 entry beats return");
        step(6'd0,    1, 0, 0, 0,          "R6 nested return to irq");
        step(6'd0,    1, 0, 0, 0,          "R6 return irq to user");
        step(RQ_PABT | RQ_SWI | RQ_UND, 0, 0, 0, 32'h6000, "R2 pabt over und");
        step(6'd0,    1, 0, 0, 0,          "R7 pabt return minus 4");
        step(RQ_SWI | RQ_UND, 0, 0, 0, 32'h7000, "R12 und over swi");
        step(6'd0,    1, 0, 0, 0,          "R7 und return offset 0");
        step(RQ_SWI,  0, 0, 0, 32'h8000,   "R4 swi vector");
        step(6'd0,    0, 1, 32'hD3, 0,     "R9 privileged write masks");
        step(RQ_FIQ | RQ_IRQ, 0, 0, 0, 32'h8800, "R3 both interrupts masked");
        step(6'd0,    0, 1, 32'h93, 0,     "R9 clear fast mask");
        step(RQ_FIQ | RQ_IRQ, 0, 0, 0, 32'h9000, "R5 fiq sets both masks");
        step(6'd0,    1, 0, 0, 0,          "R6 fiq return restores");
        step(6'd0,    0, 1, 32'h53, 0,     "R9 fast mask only");
        step(RQ_FIQ,  0, 0, 0, 32'h9800,   "R3 fiq masked");
        step(RQ_IRQ,  0, 0, 0, 32'hA000,   "R5 irq keeps fast mask");
        step(6'd0,    1, 1, 32'h1F, 0,     "R11 return beats write");
        step(RQ_SWI,  0, 1, 32'h1F, 32'hB000, "R11 entry beats write");
        step(6'd0,    0, 1, 32'hA5A5A5A0, 0, "R9 illegal mode kept");
        chk("R9 illegal mode literal", status, 32'hA5A5A5B3);
        step(6'd0,    1, 0, 0, 0,          "R7 svc return");
        chk("R6 final status literal", status, 32'h00000053);

        repeat (4) @(posedge clk);
        #1;
        chk("R13 all redirects seen", exp_q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule